// File: doc/BRIEF.md
# Legacy Address Mode Access Checker

This block sits between a processor core and its memory interface. It holds the processor status word and checks every access against two configuration inputs: one enables full-width program addressing, the other full-width data addressing. In the narrow configuration it flags address exceptions for accesses that leave the low 64 MB. When full-width program addressing is on and the core runs in a narrow mode (status bit 4 clear), it flags a data abort for data accesses to the 32-byte exception-vector region at the bottom of memory.

Accesses come in on a valid/ready request channel, and verdicts leave on a valid/ready response channel. The response register holds one entry. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high while the response register is empty, or while the sink takes the current response in the same cycle. A response stays stable while `rsp_valid` is high and `rsp_ready` is low. Configuration and status-word pins are plain signals.

The block also keeps the status word and filters writes to it. With full-width program addressing off, the mode bits [4:2] cannot change, so the core stays in narrow modes. The status word resets to the narrow supervisor mode. Narrow-configuration aborts and undefined-instruction exceptions are taken in that mode.

Top module: `lgc_access_checker`

## Requirements
- R1: With `cfg_prog_wide`=0 and `cfg_data_wide`=0, a data access whose address has any bit of [31:26] set returns `rsp_addr_exc`=1.
- R2: With `cfg_data_wide`=1, a data access never returns `rsp_addr_exc`, whatever its address.
- R3: With `cfg_prog_wide`=0, an instruction fetch (`req_fetch`=1) whose address has any bit of [31:26] set returns `rsp_addr_exc`=1. With `cfg_prog_wide`=1, a fetch never does.
- R4: With `cfg_prog_wide`=1 and status bit 4 = 0, a data write to 0x00–0x1F returns `rsp_vec_abort`=1. An access to 0x20 or higher never does.
- R5: An instruction fetch never returns `rsp_vec_abort`.
- R6: A data read of 0x00–0x1F under the conditions of R4 returns `rsp_vec_abort` exactly when parameter `TRAP_VEC_READS` is 1 (the default).
- R7: With status bit 4 = 1, or with `cfg_prog_wide`=0, no access returns `rsp_vec_abort`.
- R8: A response appears in the cycle after acceptance and carries the accepted address in `rsp_addr`. It holds steady while `rsp_ready` is low. `req_ready` = !`rsp_valid` || `rsp_ready`.
- R9: With `cfg_prog_wide`=0, a write on `sr_we` updates every status bit except [4:2], which keep their previous value.
- R10: With `cfg_prog_wide`=1, a write on `sr_we` loads all 32 bits of `sr_wdata`.
- R11: After reset, `rsp_valid`=0 and `sr_value`=0x00000003 (narrow supervisor mode).
- R12: A response never has both fault flags set. The address exception takes priority.
- R13: The checks use the configuration and status word present in the accept cycle, before any status write in that same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prog_wide | input | 1 | Full-width program addressing enable |
| cfg_data_wide | input | 1 | Full-width data addressing enable |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Sink takes the verdict |
| rsp_addr_exc | output | 1 | Address exception |
| rsp_vec_abort | output | 1 | Vector-region data abort |
| rsp_addr | output | 32 | Address of the checked access |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| sr_value | output | 32 | Filtered status word |

## Verification
The assertions assume that reset is asserted for at least one edge before any traffic. They also assume that the configuration pins change only between edges, so each accepted request sees one stable configuration. The bench drives every input on the falling edge and holds reset for several cycles. It toggles the configuration only at those falling edges. Random traffic mixes vector-region, mid-range and high addresses with random back-pressure, and it lets status writes coincide with accepted requests to cover R13.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned NARROW_W  = 26;
  localparam int unsigned VEC_BYTES = 32;
  localparam int unsigned SR_W      = 32;
  localparam int unsigned MODE_LO   = 2;
  localparam int unsigned MODE_HI   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              write;
    logic              fetch;
  } access_t;

  typedef struct packed {
    logic addr_exc;
    logic vec_abort;
  } verdict_t;
endpackage

// File: rtl/lgc_range_check.sv
module lgc_range_check #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 26
) (
  input  logic              prog_wide,
  input  logic              data_wide,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_exc
);
  localparam int unsigned HI_W = ADDR_W - NARROW_W;

  logic [HI_W-1:0] hi_bits;
  logic            range_limited;

  assign hi_bits = addr[ADDR_W-1:NARROW_W];

  // Fetches are limited by the program width, data by both widths.
  always_comb begin
    if (fetch) range_limited = !prog_wide;
    else       range_limited = !prog_wide && !data_wide;
  end

  assign addr_exc = range_limited && (|hi_bits);
endmodule

// File: rtl/lgc_vector_check.sv
module lgc_vector_check #(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned VEC_BYTES      = 32,
  parameter bit          TRAP_VEC_READS = 1'b1
) (
  input  logic              prog_wide,
  input  logic              narrow_mode,
  input  logic              fetch,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              vec_abort
);
  localparam int unsigned VEC_LSB = $clog2(VEC_BYTES);

  logic in_vectors;
  logic kind_trapped;

  assign in_vectors = (addr[ADDR_W-1:VEC_LSB] == '0);

  generate
    if (TRAP_VEC_READS) begin : g_rd_trap
      assign kind_trapped = !fetch;
    end else begin : g_wr_only
      assign kind_trapped = !fetch && write;
    end
  endgenerate

  assign vec_abort = prog_wide && narrow_mode && kind_trapped && in_vectors;
endmodule

// File: rtl/lgc_mode_filter.sv
module lgc_mode_filter #(
  parameter int unsigned            SR_W      = 32,
  parameter int unsigned            MODE_LO   = 2,
  parameter int unsigned            MODE_HI   = 4,
  parameter logic [SR_W-1:0]        RESET_VAL = 32'h0000_0003
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_wide,
  input  logic            we,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] sr_q
);
  logic [SR_W-1:0] sr_d;

  for (genvar b = 0; b < SR_W; b++) begin : g_bit
    if (b >= MODE_LO && b <= MODE_HI) begin : g_locked
      assign sr_d[b] = (we && prog_wide) ? wdata[b] : sr_q[b];
    end else begin : g_free
      assign sr_d[b] = we ? wdata[b] : sr_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= RESET_VAL;
    else     sr_q <= sr_d;
  end

  // R9: locked mode bits hold across a narrow-configuration write
  p_mode_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (we && !prog_wide) |=> (sr_q[MODE_HI:MODE_LO] == $past(sr_q[MODE_HI:MODE_LO])));

  // R10: full-width configuration loads the written value
  p_full_write_r10: assert property (@(posedge clk) disable iff (rst)
    (we && prog_wide) |=> (sr_q == $past(wdata)));
endmodule

// File: rtl/lgc_access_checker.sv
module lgc_access_checker
  import lgc_pkg::*;
#(
  parameter bit TRAP_VEC_READS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_prog_wide,
  input  logic              cfg_data_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_addr_exc,
  output logic              rsp_vec_abort,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  output logic [SR_W-1:0]   sr_value
);
  access_t  acc;
  verdict_t raw, final_v;
  logic     accept;
  logic     rsp_fetch_q;

  assign acc.addr  = req_addr;
  assign acc.write = req_write;
  assign acc.fetch = req_fetch;

  lgc_mode_filter #(
    .SR_W(SR_W), .MODE_LO(MODE_LO), .MODE_HI(MODE_HI), .RESET_VAL(32'h0000_0003)
  ) u_mode (
    .clk(clk), .rst(rst), .prog_wide(cfg_prog_wide),
    .we(sr_we), .wdata(sr_wdata), .sr_q(sr_value)
  );

  lgc_range_check #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_range (
    .prog_wide(cfg_prog_wide), .data_wide(cfg_data_wide),
    .fetch(acc.fetch), .addr(acc.addr), .addr_exc(raw.addr_exc)
  );

  lgc_vector_check #(
    .ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .TRAP_VEC_READS(TRAP_VEC_READS)
  ) u_vec (
    .prog_wide(cfg_prog_wide), .narrow_mode(!sr_value[MODE_HI]),
    .fetch(acc.fetch), .write(acc.write), .addr(acc.addr),
    .vec_abort(raw.vec_abort)
  );

  // Address exception outranks the vector abort.
  assign final_v.addr_exc  = raw.addr_exc;
  assign final_v.vec_abort = raw.vec_abort && !raw.addr_exc;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_addr_exc  <= 1'b0;
      rsp_vec_abort <= 1'b0;
      rsp_addr      <= '0;
      rsp_fetch_q   <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_addr_exc  <= final_v.addr_exc;
      rsp_vec_abort <= final_v.vec_abort;
      rsp_addr      <= acc.addr;
      rsp_fetch_q   <= acc.fetch;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: never two faults on one verdict
  p_single_fault_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_addr_exc && rsp_vec_abort));

  // R8: stalled response holds
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_addr_exc) && $stable(rsp_vec_abort)));

  // R8: accepted request yields a response next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid && rsp_addr == $past(req_addr)));

  // R5: fetches never take the vector abort
  p_fetch_no_vec_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fetch_q) |-> !rsp_vec_abort);
endmodule

// File: tb/test_lgc_access_checker.sv
module test_lgc_access_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_prog_wide = 1'b0, cfg_data_wide = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_ready = 1'b1;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic        req_ready, rsp_valid, rsp_addr_exc, rsp_vec_abort;
  logic [31:0] rsp_addr, sr_value;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  // behavioural model state
  bit          m_valid, m_exc, m_vab;
  logic [31:0] m_addr, m_sr;

  always #10 clk = ~clk;

  lgc_access_checker i_lgc_access_checker (
    .clk(clk), .rst(rst), .cfg_prog_wide(cfg_prog_wide), .cfg_data_wide(cfg_data_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr_exc(rsp_addr_exc), .rsp_vec_abort(rsp_vec_abort),
    .rsp_addr(rsp_addr), .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_value(sr_value)
  );

  always @(posedge clk) begin
    bit rdy, e, v;
    if (rst) begin
      m_valid = 0; m_exc = 0; m_vab = 0; m_addr = '0; m_sr = 32'h3;
    end else begin
      rdy = !m_valid || rsp_ready;
      if (req_valid && rdy) begin
        // R1 R2 R3: range rules
        if (req_fetch) e = !cfg_prog_wide && (req_addr >= 32'h0400_0000);
        else           e = !cfg_prog_wide && !cfg_data_wide && (req_addr >= 32'h0400_0000);
        // R4 R5 R6 R7 R13: vector rules with the pre-write status word
        v = cfg_prog_wide && (m_sr[4] == 1'b0) && !req_fetch && (req_addr < 32);
        m_valid = 1; m_exc = e; m_vab = v && !e; m_addr = req_addr;
      end else if (rsp_ready) m_valid = 0;
      // R9 R10
      if (sr_we) begin
        if (cfg_prog_wide) m_sr = sr_wdata;
        else m_sr = {sr_wdata[31:5], m_sr[4:2], sr_wdata[1:0]};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8/R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_valid});
    chk("R9/R10/R11 sr_value", sr_value, m_sr);
    if (m_valid) begin
      chk("R1/R2/R3 rsp_addr_exc", {31'b0, rsp_addr_exc}, {31'b0, m_exc});
      chk("R4/R5/R6/R7/R12 rsp_vec_abort", {31'b0, rsp_vec_abort}, {31'b0, m_vab});
      chk("R8 rsp_addr", rsp_addr, m_addr);
    end
  endtask

  task automatic step(input bit pw, input bit dw, input bit vld, input logic [31:0] a,
                      input bit w, input bit f, input bit rr, input bit we, input logic [31:0] wd);
    @(negedge clk);
    compare();
    cfg_prog_wide = pw; cfg_data_wide = dw; req_valid = vld; req_addr = a;
    req_write = w; req_fetch = f; rsp_ready = rr; sr_we = we; sr_wdata = wd;
    #1 chk("R8 req_ready", {31'b0, req_ready}, {31'b0, (!m_valid || rsp_ready)});
  endtask

  initial begin : wd
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 reset sr_value", sr_value, 32'h3);
    chk("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    // R1 narrow config high data address
    step(0, 0, 1, 32'h0400_0000, 0, 0, 1, 0, 0);
    // R2 data wide
    step(0, 1, 1, 32'hFC00_0010, 1, 0, 1, 0, 0);
    // R3 fetch high in narrow program config, then wide
    step(0, 1, 1, 32'h8000_0000, 0, 1, 1, 0, 0);
    step(1, 0, 1, 32'h8000_0000, 0, 1, 1, 0, 0);
    // R4 vector write, boundary 0x1F and 0x20
    step(1, 0, 1, 32'h0000_001F, 1, 0, 1, 0, 0);
    step(1, 0, 1, 32'h0000_0020, 1, 0, 1, 0, 0);
    // R5 fetch of vector
    step(1, 0, 1, 32'h0000_0000, 0, 1, 1, 0, 0);
    // R6 data read of vector
    step(1, 0, 1, 32'h0000_0004, 0, 0, 1, 0, 0);
    // R7 narrow program config: no vector abort
    step(0, 0, 1, 32'h0000_0008, 1, 0, 1, 0, 0);
    // R9 locked write tries to set bit 4
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hA000_001F);
    // R10 wide write sets bit 4; R13 concurrent vector write still aborts
    step(1, 0, 1, 32'h0000_0010, 1, 0, 1, 1, 32'h0000_0013);
    // R7 bit 4 set -> no abort
    step(1, 0, 1, 32'h0000_0010, 1, 0, 1, 0, 0);
    // R8 back-pressure
    step(1, 0, 1, 32'h0000_0100, 0, 0, 0, 0, 0);
    step(1, 0, 1, 32'h0000_0200, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0003);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = $urandom_range(0, 63);
        1: a = {6'b0, 26'($urandom)};
        2: a = $urandom | 32'h0400_0000;
        default: a = $urandom;
      endcase
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) != 0, a,
           $urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 7) == 0, $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule